// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the privileged-state side of taking an exception in a small RISC core. A one-cycle request carries an exception code, two qualifier bits (TLB refill, external interrupt), the faulting virtual address and a coprocessor number. On the clock edge that accepts the request, the block does several things at once:

- it sets the exception-level flag;
- it records the return address, correcting it for a branch-delay slot;
- it rewrites the code and coprocessor fields of the cause register;
- it latches the bad address and the translation fields when they apply;
- it swaps the shadow register set selectors.

In the same edge it picks the handler address. In the following cycle it presents a one-cycle redirect of PC, next PC and next-next PC to the fetch stage.

After reset the block issues one redirect to the boot vector. The privileged registers live inside the block. Software reaches them through a simple write port and a combinational read port, selected by a 3-bit code: 0 status, 1 cause, 2 exception PC, 3 bad address, 4 shadow-set control, 5 translation entry-high, 6 translation context. The TLB lookup, the pipeline flush and interrupt arbitration belong to neighbouring blocks.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is held, busy is 1 and rdValid is 0. In the first cycle after reset is released, rdValid is 1 for exactly one cycle with rdPc = 0xBFC00000, rdNextPc = 0xBFC00004 and rdNextNextPc = 0xBFC00008. Status resets to 0x20400000: bit 29 marks the floating-point coprocessor usable and bit 22 (the boot-vector flag, BEV) is set.
- R2: On every accepted request, status bit 1 (EXL) becomes 1, whatever its previous value. All other status bits are kept.
- R3: Shadow-set control fields are: current set in bits [3:0], previous set in bits [9:6], exception set in bits [15:12]. When EXL and BEV were both 0 before entry, the previous set takes the old current set and the current set takes the exception set. Otherwise the register is unchanged.
- R4: When curPc + 4 equals curNextPc, the exception PC becomes curPc and cause bit 31 (BD) is cleared. Otherwise the exception PC becomes curPc - 4 and BD is set.
- R5: Cause bits [6:2] take the request code. Cause bits [29:28] are cleared, except for code 0x0B (coprocessor unusable), where they take reqCopId. Other cause bits are kept.
- R6: The handler address is ebase + 0x180 unless R7, R8 or R9 applies. This includes code 0x0A with reqIntr = 0 (reserved instruction) and overflow with BEV = 0.
- R7: For a TLB refill (reqRefill = 1 with code 0x2 or 0x3), the handler is ebase + 0x000 when EXL was 0 before entry and ebase + 0x180 when it was 1.
- R8: For an interrupt (code 0x0A with reqIntr = 1), the handler is ebase + 0x200 when cause bit 23 (IV) is 1 and ebase + 0x180 when it is 0.
- R9: For an overflow (code 0x0C) with BEV = 1, the handler is the fixed address 0xBFC00200.
- R10: Codes 0x1 to 0x5 write reqAddr to the bad-address register. Codes 0x1 to 0x3 also write reqAddr[31:13] into entry-high bits [31:13] and into context bits [22:4]. Other codes leave these three registers unchanged.
- R11: A request accepted at one clock edge gives rdValid = 1 in the next cycle only, with rdPc = handler, rdNextPc = handler + 4 and rdNextNextPc = handler + 8.
- R12: busy is 1 while a redirect is presented. A request seen while busy is ignored: it produces no redirect and no register change.
- R13: A software write in the same cycle as an accepted request is dropped, even to a register the exception does not touch. Writes in other cycles, including busy cycles, take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Exception request strobe |
| reqCode | input | 5 | Exception code |
| reqRefill | input | 1 | TLB exception is a refill (no matching entry) |
| reqIntr | input | 1 | Code 0x0A is an interrupt rather than a reserved instruction |
| reqAddr | input | 32 | Faulting virtual address |
| reqCopId | input | 2 | Coprocessor number for code 0x0B |
| curPc | input | 32 | PC of the faulting instruction |
| curNextPc | input | 32 | Next PC at the time of the fault |
| ebase | input | 32 | Exception base address |
| regWrEn | input | 1 | Software register write enable |
| regWrSel | input | 3 | Register select for the write |
| regWrData | input | 32 | Write data |
| regRdSel | input | 3 | Register select for the read |
| regRdData | output | 32 | Read data (combinational) |
| busy | output | 1 | Request would be ignored this cycle |
| rdValid | output | 1 | Redirect strobe |
| rdPc | output | 32 | Redirect PC |
| rdNextPc | output | 32 | Redirect next PC |
| rdNextNextPc | output | 32 | Redirect next-next PC |

## Verification
Two functions can fall in the same cycle: an exception entry and a software register write. The bench provokes them together twice. In the first case the write goes to status with data 0 while the request is accepted; the status read afterwards must show the old value with only EXL added. In the second case the write goes to the bad-address register during a syscall, which does not touch that register; the old value must survive. A second overlap, a new request arriving in the redirect cycle, is judged by rdValid staying low afterwards and the cause code keeping the first request's value.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;
  localparam int CODE_W = 5;
  localparam int COP_W  = 2;

  // register select codes
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_EPC    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_BAD    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SRS    = 3'd4;
  localparam logic [SEL_W-1:0] SEL_ENTHI  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_CTX    = 3'd6;

  // exception codes the block treats specially
  localparam logic [CODE_W-1:0] CODE_TLB_MOD = 5'h01;
  localparam logic [CODE_W-1:0] CODE_TLB_LD  = 5'h02;
  localparam logic [CODE_W-1:0] CODE_TLB_ST  = 5'h03;
  localparam logic [CODE_W-1:0] CODE_ADE_ST  = 5'h05;
  localparam logic [CODE_W-1:0] CODE_INT     = 5'h0A;
  localparam logic [CODE_W-1:0] CODE_COPU    = 5'h0B;
  localparam logic [CODE_W-1:0] CODE_OVF     = 5'h0C;

  // field positions
  localparam int ST_EXL   = 1;
  localparam int ST_BEV   = 22;
  localparam int ST_CU1   = 29;
  localparam int CA_BD    = 31;
  localparam int CA_IV    = 23;
  localparam int CA_CE_LO = 28;
  localparam int CA_EC_LO = 2;
  localparam int SRS_CUR  = 0;
  localparam int SRS_PRV  = 6;
  localparam int SRS_EXC  = 12;
  localparam int SET_W    = 4;
  localparam int VPN_LO   = 13;
  localparam int VPN_W    = DATA_W - VPN_LO;
  localparam int CTX_LO   = 4;

  typedef struct packed {
    logic commit;
    logic swapSet;
    logic loadBad;
    logic loadTlb;
    logic ceFromCop;
    logic bootVec;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_BOOT     = 2'd0,
    ST_BOOTREDIR = 2'd1,
    ST_IDLE     = 2'd2,
    ST_REDIR    = 2'd3
  } ctlState_e;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              exlNow,
  input  logic              bevNow,
  output ctlStrobe_t        strobe,
  output logic              busy,
  output logic              rdValid
);
  ctlState_e stateQ, stateD;
  logic accept;
  logic codeBad, codeTlb;

  assign accept  = reqValid && (stateQ == ST_IDLE);
  assign codeBad = (reqCode >= CODE_TLB_MOD) && (reqCode <= CODE_ADE_ST);
  assign codeTlb = (reqCode >= CODE_TLB_MOD) && (reqCode <= CODE_TLB_ST);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_BOOT:      stateD = ST_BOOTREDIR;
      ST_BOOTREDIR: stateD = ST_IDLE;
      ST_IDLE:      stateD = accept ? ST_REDIR : ST_IDLE;
      ST_REDIR:     stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_BOOT;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobe.commit    = accept;
    strobe.swapSet   = accept && !exlNow && !bevNow;
    strobe.loadBad   = accept && codeBad;
    strobe.loadTlb   = accept && codeTlb;
    strobe.ceFromCop = accept && (reqCode == CODE_COPU);
    strobe.bootVec   = (stateQ == ST_BOOT);
  end

  assign busy    = (stateQ != ST_IDLE);
  assign rdValid = (stateQ == ST_BOOTREDIR) || (stateQ == ST_REDIR);

  AST_ACCEPT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    accept |=> rdValid); // R11
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid); // R11
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (rdValid && reqValid) |=> !rdValid); // R12
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !strobe.commit); // R12
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [DATA_W-1:0] BOOT_OVF   = 32'hBFC0_0200,
  parameter logic [DATA_W-1:0] GEN_OFS    = 32'h0000_0180,
  parameter logic [DATA_W-1:0] INT_OFS    = 32'h0000_0200,
  parameter int                INSN_BYTES = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              reqRefill,
  input  logic              reqIntr,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [COP_W-1:0]  reqCopId,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curNextPc,
  input  logic [DATA_W-1:0] ebase,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [SEL_W-1:0]  regRdSel,
  output logic [DATA_W-1:0] regRdData,
  output logic              exlNow,
  output logic              bevNow,
  output logic [DATA_W-1:0] rdPc,
  output logic [DATA_W-1:0] rdNextPc,
  output logic [DATA_W-1:0] rdNextNextPc
);
  localparam logic [DATA_W-1:0] STEP       = DATA_W'(INSN_BYTES);
  localparam logic [DATA_W-1:0] STATUS_RST = (DATA_W'(1) << ST_CU1) | (DATA_W'(1) << ST_BEV);

  logic [DATA_W-1:0] statusQ, causeQ, epcQ, badQ, srsQ, entHiQ, ctxQ, handlerQ;
  logic [DATA_W-1:0] handlerD;
  logic inSlot, isRefill, isIntr, swWrite;

  assign exlNow   = statusQ[ST_EXL];
  assign bevNow   = statusQ[ST_BEV];
  assign inSlot   = (curPc + STEP) != curNextPc;
  assign isRefill = reqRefill && ((reqCode == CODE_TLB_LD) || (reqCode == CODE_TLB_ST));
  assign isIntr   = reqIntr && (reqCode == CODE_INT);
  assign swWrite  = regWrEn && !strobe.commit;

  // handler selection, using register values from before entry
  always_comb begin
    if (isRefill)
      handlerD = exlNow ? (ebase + GEN_OFS) : ebase;
    else if (isIntr)
      handlerD = causeQ[CA_IV] ? (ebase + INT_OFS) : (ebase + GEN_OFS);
    else if ((reqCode == CODE_OVF) && bevNow)
      handlerD = BOOT_OVF;
    else
      handlerD = ebase + GEN_OFS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= STATUS_RST;
    end else if (strobe.commit) begin
      statusQ[ST_EXL] <= 1'b1;
    end else if (swWrite && regWrSel == SEL_STATUS) begin
      statusQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      causeQ <= '0;
    end else if (strobe.commit) begin
      causeQ[CA_BD] <= inSlot;
      causeQ[CA_CE_LO +: COP_W]  <= strobe.ceFromCop ? reqCopId : '0;
      causeQ[CA_EC_LO +: CODE_W] <= reqCode;
    end else if (swWrite && regWrSel == SEL_CAUSE) begin
      causeQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epcQ <= '0;
    end else if (strobe.commit) begin
      epcQ <= inSlot ? (curPc - STEP) : curPc;
    end else if (swWrite && regWrSel == SEL_EPC) begin
      epcQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      badQ <= '0;
    end else if (strobe.loadBad) begin
      badQ <= reqAddr;
    end else if (swWrite && regWrSel == SEL_BAD) begin
      badQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srsQ <= '0;
    end else if (strobe.swapSet) begin
      srsQ[SRS_PRV +: SET_W] <= srsQ[SRS_CUR +: SET_W];
      srsQ[SRS_CUR +: SET_W] <= srsQ[SRS_EXC +: SET_W];
    end else if (swWrite && regWrSel == SEL_SRS) begin
      srsQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entHiQ <= '0;
      ctxQ   <= '0;
    end else if (strobe.loadTlb) begin
      entHiQ[VPN_LO +: VPN_W] <= reqAddr[VPN_LO +: VPN_W];
      ctxQ[CTX_LO +: VPN_W]   <= reqAddr[VPN_LO +: VPN_W];
    end else if (swWrite) begin
      if (regWrSel == SEL_ENTHI) entHiQ <= regWrData;
      if (regWrSel == SEL_CTX)   ctxQ   <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 handlerQ <= RESET_VEC;
    else if (strobe.bootVec) handlerQ <= RESET_VEC;
    else if (strobe.commit)  handlerQ <= handlerD;
  end

  assign rdPc         = handlerQ;
  assign rdNextPc     = handlerQ + STEP;
  assign rdNextNextPc = handlerQ + STEP + STEP;

  always_comb begin
    unique case (regRdSel)
      SEL_STATUS: regRdData = statusQ;
      SEL_CAUSE:  regRdData = causeQ;
      SEL_EPC:    regRdData = epcQ;
      SEL_BAD:    regRdData = badQ;
      SEL_SRS:    regRdData = srsQ;
      SEL_ENTHI:  regRdData = entHiQ;
      SEL_CTX:    regRdData = ctxQ;
      default:    regRdData = '0;
    endcase
  end

  AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> statusQ[ST_EXL]); // R2
  AST_SET_SWAP: assert property (@(posedge clk) disable iff (rst)
    strobe.swapSet |=> (srsQ[SRS_PRV +: SET_W] == $past(srsQ[SRS_CUR +: SET_W]))); // R3
  AST_EPC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && (curNextPc == curPc + STEP)) |=> (epcQ == $past(curPc) && !causeQ[CA_BD])); // R4
  AST_CE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && reqCode != CODE_COPU) |=> (causeQ[CA_CE_LO +: COP_W] == '0)); // R5
  AST_REFILL_BASE: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && isRefill && !exlNow) |=> (rdPc == $past(ebase))); // R7
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              reqRefill,
  input  logic              reqIntr,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [COP_W-1:0]  reqCopId,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curNextPc,
  input  logic [DATA_W-1:0] ebase,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [SEL_W-1:0]  regRdSel,
  output logic [DATA_W-1:0] regRdData,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdPc,
  output logic [DATA_W-1:0] rdNextPc,
  output logic [DATA_W-1:0] rdNextNextPc
);
  ctlStrobe_t strobe;
  logic exlNow, bevNow;

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCode(reqCode),
    .exlNow(exlNow), .bevNow(bevNow), .strobe(strobe),
    .busy(busy), .rdValid(rdValid)
  );

  exc_entry_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqCode(reqCode),
    .reqRefill(reqRefill), .reqIntr(reqIntr), .reqAddr(reqAddr),
    .reqCopId(reqCopId), .curPc(curPc), .curNextPc(curNextPc), .ebase(ebase),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData), .exlNow(exlNow), .bevNow(bevNow),
    .rdPc(rdPc), .rdNextPc(rdNextPc), .rdNextNextPc(rdNextNextPc)
  );
endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/100ps
module sim_exc_entry_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 0, reqRefill = 0, reqIntr = 0, regWrEn = 0;
  logic [4:0] reqCode = '0;
  logic [1:0] reqCopId = '0;
  logic [2:0] regWrSel = '0, regRdSel = '0;
  logic [31:0] reqAddr = '0, curPc = '0, curNextPc = '0, ebase = 32'h8000_0000, regWrData = '0;
  logic [31:0] regRdData, rdPc, rdNextPc, rdNextNextPc;
  logic busy, rdValid;
  int checks = 0, errors = 0;

  exc_entry_unit u0 (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [4:0]  code;
    logic        refill, intr, exl, bev, iv;
    logic [31:0] pc, npc, addr;
    logic [1:0]  cop;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_1004, 32'h1111_0000, 2'd0},
    '{5'h09, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_3000, 32'h2222_0000, 2'd0},
    '{5'h0D, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_3004, 32'h3333_0000, 2'd0},
    '{5'h0C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_4000, 32'h0000_4004, 32'h4444_0000, 2'd0},
    '{5'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4100, 32'h0000_4104, 32'h4545_0000, 2'd0},
    '{5'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_5000, 32'h0000_5004, 32'h1234_5678, 2'd0},
    '{5'h03, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_6000, 32'h0000_6800, 32'hFEDC_BA98, 2'd0},
    '{5'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_7000, 32'h0000_7004, 32'hA5A5_E000, 2'd0},
    '{5'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_8004, 32'h5555_0000, 2'd0},
    '{5'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_8100, 32'h0000_8104, 32'h5656_0000, 2'd0},
    '{5'h0A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_9000, 32'h0000_9004, 32'h6666_0000, 2'd0},
    '{5'h0B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_A000, 32'h0000_A004, 32'h7777_0000, 2'd2},
    '{5'h04, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_B000, 32'h0000_B004, 32'h0BAD_0001, 2'd0},
    '{5'h05, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_C000, 32'h0000_D000, 32'h0BAD_0003, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [31:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] sel, output logic [31:0] val);
    regRdSel = sel;
    #0.2;
    val = regRdData;
  endtask

  function automatic logic [31:0] expHandler(input vec_t v);
    if (v.refill && (v.code == 5'h02 || v.code == 5'h03))
      return v.exl ? ebase + 32'h180 : ebase;              // R7
    if (v.intr && v.code == 5'h0A)
      return v.iv ? ebase + 32'h200 : ebase + 32'h180;     // R8
    if (v.code == 5'h0C && v.bev) return 32'hBFC0_0200;    // R9
    return ebase + 32'h180;                                // R6
  endfunction

  task automatic runVec(input vec_t v);
    logic [31:0] st0, rv, hnd, expEpc, expCause, expSrs;
    logic slot, tlb, bad;
    st0 = (32'(v.exl) << 1) | (32'(v.bev) << 22) | 32'h2000_0000;
    writeReg(3'd0, st0);
    writeReg(3'd1, (32'(v.iv) << 23) | 32'h3000_007C);
    writeReg(3'd4, 32'h0000_5243);
    writeReg(3'd3, 32'hDEAD_0000);
    writeReg(3'd5, 32'h0);
    writeReg(3'd6, 32'h0);
    reqValid = 1'b1; reqCode = v.code; reqRefill = v.refill; reqIntr = v.intr;
    reqAddr = v.addr; reqCopId = v.cop; curPc = v.pc; curNextPc = v.npc;
    @(negedge clk);
    reqValid = 1'b0;
    hnd = expHandler(v);
    check("R11 rdValid", 32'(rdValid), 32'd1);
    check("R11/R6-R9 rdPc", rdPc, hnd);
    check("R11 rdNextPc", rdNextPc, hnd + 32'd4);
    check("R11 rdNextNextPc", rdNextNextPc, hnd + 32'd8);
    check("R12 busy in redirect", 32'(busy), 32'd1);
    slot = (v.pc + 32'd4) != v.npc;
    expEpc = slot ? v.pc - 32'd4 : v.pc;
    expCause = (32'(v.iv) << 23) | (32'(slot) << 31) | (32'(v.code) << 2) |
               ((v.code == 5'h0B) ? (32'(v.cop) << 28) : 32'h0);
    expSrs = (!v.exl && !v.bev) ? 32'h0000_50C5 : 32'h0000_5243;
    tlb = (v.code >= 5'h01) && (v.code <= 5'h03);
    bad = (v.code >= 5'h01) && (v.code <= 5'h05);
    readReg(3'd0, rv); check("R2 status EXL", rv, st0 | 32'h2);
    readReg(3'd1, rv); check("R5/R4 cause", rv, expCause);
    readReg(3'd2, rv); check("R4 epc", rv, expEpc);
    readReg(3'd4, rv); check("R3 shadow set", rv, expSrs);
    readReg(3'd3, rv); check("R10 bad address", rv, bad ? v.addr : 32'hDEAD_0000);
    readReg(3'd5, rv); check("R10 entry-high", rv, tlb ? {v.addr[31:13], 13'h0} : 32'h0);
    readReg(3'd6, rv); check("R10 context", rv, tlb ? {9'h0, v.addr[31:13], 4'h0} : 32'h0);
    @(negedge clk);
    check("R11 strobe one cycle", 32'(rdValid), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd1);
    check("R1 no redirect in reset", 32'(rdValid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 boot redirect", 32'(rdValid), 32'd1);
    check("R1 boot pc", rdPc, 32'hBFC0_0000);
    check("R1 boot npc", rdNextPc, 32'hBFC0_0004);
    check("R1 boot nnpc", rdNextNextPc, 32'hBFC0_0008);
    readReg(3'd0, rv); check("R1 status reset", rv, 32'h2040_0000);
    @(negedge clk);
    check("R1 boot strobe one cycle", 32'(rdValid), 32'd0);
    check("R1 idle after boot", 32'(busy), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R13: software write to status dropped in the accept cycle
    writeReg(3'd0, 32'h2000_0000);
    reqValid = 1'b1; reqCode = 5'h08; reqRefill = 0; reqIntr = 0;
    curPc = 32'h100; curNextPc = 32'h104;
    regWrEn = 1'b1; regWrSel = 3'd0; regWrData = 32'h0;
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0;
    readReg(3'd0, rv); check("R13 status write dropped", rv, 32'h2000_0002);
    @(negedge clk);

    // R13: write to an untouched register also dropped
    writeReg(3'd3, 32'hCAFE_0000);
    reqValid = 1'b1; reqCode = 5'h08; reqAddr = 32'h9999_0000;
    regWrEn = 1'b1; regWrSel = 3'd3; regWrData = 32'h0000_1234;
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0;
    readReg(3'd3, rv); check("R13 bad address write dropped", rv, 32'hCAFE_0000);
    // R13: write during busy cycle takes effect
    writeReg(3'd2, 32'h0000_ABCC);
    readReg(3'd2, rv); check("R13 write while busy", rv, 32'h0000_ABCC);

    // R12: request arriving in the redirect cycle is ignored
    reqValid = 1'b1; reqCode = 5'h09; curPc = 32'h200; curNextPc = 32'h204;
    @(negedge clk);
    check("R12 first redirect", 32'(rdValid), 32'd1);
    reqCode = 5'h0D; curPc = 32'h300; curNextPc = 32'h304;
    @(negedge clk);
    reqValid = 1'b0;
    check("R12 no second redirect", 32'(rdValid), 32'd0);
    readReg(3'd1, rv); check("R12 cause code kept", 32'(rv[6:2]), 32'h09);
    readReg(3'd2, rv); check("R12 epc kept", rv, 32'h200);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule